// File: doc/BRIEF.md
# Mixed-Cell Boundary Scan Register

This block is the data-register side of a boundary scan chain whose cells are not all alike. One chain holds input cells, observe-only cells, two-state output cells, three-state output cells, enable-control cells and reversible bidirectional cells. The cell order, the kind of each cell, the control cell that governs each three-state or bidirectional pin, the reset value of each update latch and the set of control cells that are forced off in test-logic-reset are all parameters.

A separate test access port controller supplies the state decodes (capture, shift, update, test-logic-reset) and the instruction decode that selects test mode. The block moves data on the scan clock. Captures and shifts happen on the rising edge. The update latches, and every pin-side value taken from them, change only on the falling edge. When test mode is off, system data and system enables reach the pins unchanged, and the register can still capture and shift in the background.

Top module: `bsr_chain`

## Requirements
- R1: In the capture state, each cell loads on a rising edge the value it observes. Input and observe-only cells load their pin input. Two-state and three-state output cells load their system data. Control cells load their system enable.
- R2: In the shift state (with capture low), each rising edge moves every stage one place toward `tdo_o`. `tdi_i` enters the last cell (index N_CELLS-1). `tdo_o` shows the stage of cell 0 at all times. No path through the chain inverts, so a pattern shifted in comes out unchanged.
- R3: The update latches load the shift stages only on a falling edge that sees `update_i` high. Pin-side outputs taken from the latches never change on a rising edge, and shifting alone leaves them unchanged.
- R4: With `test_mode_i` high, output, bidirectional and input cells drive their data from their update latches, and governed enables come from their control cell's latch. With it low, `pin_out_o` equals `sys_out_i` for every driving cell, and each enable follows the governing control cell's bit of `sys_oe_i`.
- R5: Asserting `rst_ni` low asynchronously clears every shift stage to 0 and loads every update latch with its bit of RST_VAL.
- R6: With `tlr_i` high, the first falling edge returns every update latch to its bit of RST_VAL. Until that edge the latches keep their values.
- R7: While `tlr_i` and `test_mode_i` are both high, every pin governed by a control cell marked in CTRLR has its enable at 0, with no wait for a clock edge.
- R8: All pins that name the same control cell in CTRL_IDX carry the same enable. An enable of 1 means the pin drives.
- R9: A bidirectional cell in capture loads its pin input when its effective enable is 0, and loads its system data when the enable is 1. When enabled it drives `pin_out_o` as an output cell does.
- R10: An observe-only cell has no update latch. Its `core_in_o` always passes its pin input. An input cell's `core_in_o` passes the pin input in normal mode and its update latch in test mode. A bidirectional cell's `core_in_o` passes its pin input.
- R11: A two-state output cell always has `pin_oe_o` at 1. Cells that drive no pin hold `pin_out_o` and `pin_oe_o` at 0.
- R12: The default chain runs from cell 0 (next to TDO) to cell 7 as follows. Cell 0 is an input cell. Cell 1 is observe-only. Cell 2 is a two-state output. Cell 3 is a control cell that is forced off in test-logic-reset and governs cells 4 and 5, which are three-state outputs. Cell 6 is a control cell that is not forced off and governs cell 7, which is bidirectional. RST_VAL is 8'b0101_0100, so the latches of cells 2, 4 and 6 reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlr_i | input | 1 | Controller is in test-logic-reset |
| capture_i | input | 1 | Controller is in the data capture state |
| shift_i | input | 1 | Controller is in the data shift state |
| update_i | input | 1 | Controller is in the data update state |
| test_mode_i | input | 1 | Pins are driven from the scan cells |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, taken from cell 0 |
| pin_in_i | input | N_CELLS | Value seen at each pin |
| sys_out_i | input | N_CELLS | System data for each output cell |
| sys_oe_i | input | N_CELLS | System enable at each control cell |
| pin_out_o | output | N_CELLS | Data driven to each pin |
| pin_oe_o | output | N_CELLS | Drive enable for each pin, 1 = drive |
| core_in_o | output | N_CELLS | Pin data passed to the core side |

## Verification
The assertions check on every clock that shifting moves the chain by exactly one place and takes in `tdi_i`, and that the update latches stay still unless an update or a test-logic-reset falling edge loads them. They also check that test-logic-reset restores the reset pattern, that normal mode passes system data through, that forced control cells keep their pins disabled, and that two-state pins stay enabled. Only the bench scenarios can show the per-kind capture values. This includes the bidirectional cell switching what it captures as its controller's latch changes, the enable shared by pins in one group, the exact timing of pin changes on the falling edge and not the rising edge, and a pattern passing through the chain without being inverted.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    CK_IN,
    CK_OBS,
    CK_OUT2,
    CK_OUT3,
    CK_CTRL,
    CK_BIDIR
  } cell_kind_e;

  function automatic logic has_latch(cell_kind_e k);
    return k != CK_OBS;
  endfunction

  function automatic logic is_gated(cell_kind_e k);
    return (k == CK_OUT3) || (k == CK_BIDIR);
  endfunction

  function automatic logic is_driver(cell_kind_e k);
    return (k == CK_OUT2) || is_gated(k);
  endfunction
endpackage

// File: rtl/bsr_cell.sv
module bsr_cell #(
  parameter bit HAS_UPD = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tlr_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic obs_i,
  input  logic ser_i,
  output logic cap_o,
  output logic upd_o
);
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        cap_o <= 1'b0;
    else if (capture_i) cap_o <= obs_i;
    else if (shift_i)   cap_o <= ser_i;
  end

  if (HAS_UPD) begin : g_upd
    always_ff @(negedge tck_i or negedge rst_ni) begin
      if (!rst_ni)       upd_o <= RST_VAL;
      else if (tlr_i)    upd_o <= RST_VAL;
      else if (update_i) upd_o <= cap_o;
    end
  end else begin : g_no_upd
    logic unused_upd;
    assign unused_upd = tlr_i ^ update_i;
    assign upd_o      = 1'b0;
  end
endmodule

// File: rtl/bsr_pin_drv.sv
module bsr_pin_drv
  import bsr_pkg::*;
#(
  parameter cell_kind_e KIND = CK_IN
) (
  input  logic test_mode_i,
  input  logic upd_i,
  input  logic pin_in_i,
  input  logic sys_out_i,
  input  logic sys_en_i,
  input  logic tst_en_i,
  output logic obs_o,
  output logic pin_out_o,
  output logic pin_oe_o,
  output logic core_in_o
);
  logic drv_en, drv_dat, unused_in;

  assign drv_en    = test_mode_i ? tst_en_i : sys_en_i;
  assign drv_dat   = test_mode_i ? upd_i : sys_out_i;
  assign unused_in = test_mode_i ^ upd_i ^ pin_in_i ^ sys_out_i ^ sys_en_i ^ tst_en_i;

  always_comb begin
    obs_o     = 1'b0;
    pin_out_o = 1'b0;
    pin_oe_o  = 1'b0;
    core_in_o = 1'b0;
    case (KIND)
      CK_IN: begin
        obs_o     = pin_in_i;
        core_in_o = test_mode_i ? upd_i : pin_in_i;
      end
      CK_OBS: begin
        obs_o     = pin_in_i;
        core_in_o = pin_in_i;
      end
      CK_OUT2: begin
        obs_o     = sys_out_i;
        pin_out_o = drv_dat;
        pin_oe_o  = 1'b1;
      end
      CK_OUT3: begin
        obs_o     = sys_out_i;
        pin_out_o = drv_dat;
        pin_oe_o  = drv_en;
      end
      CK_CTRL: obs_o = sys_en_i;
      CK_BIDIR: begin
        // reversible: observe what the pin is doing in its current direction
        obs_o     = drv_en ? sys_out_i : pin_in_i;
        pin_out_o = drv_dat;
        pin_oe_o  = drv_en;
        core_in_o = pin_in_i;
      end
      default: obs_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8,
  parameter cell_kind_e  CELL_KIND [N_CELLS] = '{CK_IN, CK_OBS, CK_OUT2, CK_CTRL,
                                                 CK_OUT3, CK_OUT3, CK_CTRL, CK_BIDIR},
  parameter int unsigned CTRL_IDX  [N_CELLS] = '{0, 1, 2, 3, 3, 3, 6, 6},
  parameter logic [N_CELLS-1:0] RST_VAL = 8'b0101_0100,
  parameter logic [N_CELLS-1:0] CTRLR   = 8'b0000_1000
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tlr_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               test_mode_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  input  logic [N_CELLS-1:0] pin_in_i,
  input  logic [N_CELLS-1:0] sys_out_i,
  input  logic [N_CELLS-1:0] sys_oe_i,
  output logic [N_CELLS-1:0] pin_out_o,
  output logic [N_CELLS-1:0] pin_oe_o,
  output logic [N_CELLS-1:0] core_in_o
);
  logic [N_CELLS-1:0] cap_q, upd_q, obs, ser_in, tst_en;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam int unsigned SRC = is_gated(CELL_KIND[i]) ? CTRL_IDX[i] : i;

    if (i == N_CELLS - 1) begin : g_head
      assign ser_in[i] = tdi_i;
    end else begin : g_link
      assign ser_in[i] = cap_q[i+1];
    end

    // forced-off control cells disable their group during test-logic-reset
    assign tst_en[i] = (CTRLR[i] && tlr_i) ? 1'b0 : upd_q[i];

    bsr_cell #(
      .HAS_UPD (has_latch(CELL_KIND[i])),
      .RST_VAL (RST_VAL[i])
    ) i_cell (
      .tck_i     (tck_i),
      .rst_ni    (rst_ni),
      .tlr_i     (tlr_i),
      .capture_i (capture_i),
      .shift_i   (shift_i),
      .update_i  (update_i),
      .obs_i     (obs[i]),
      .ser_i     (ser_in[i]),
      .cap_o     (cap_q[i]),
      .upd_o     (upd_q[i])
    );

    bsr_pin_drv #(
      .KIND (CELL_KIND[i])
    ) i_drv (
      .test_mode_i (test_mode_i),
      .upd_i       (upd_q[i]),
      .pin_in_i    (pin_in_i[i]),
      .sys_out_i   (sys_out_i[i]),
      .sys_en_i    (sys_oe_i[SRC]),
      .tst_en_i    (tst_en[SRC]),
      .obs_o       (obs[i]),
      .pin_out_o   (pin_out_o[i]),
      .pin_oe_o    (pin_oe_o[i]),
      .core_in_o   (core_in_o[i])
    );
  end

  assign tdo_o = cap_q[0];
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
  import bsr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8,
  parameter cell_kind_e  CELL_KIND [N_CELLS] = '{CK_IN, CK_OBS, CK_OUT2, CK_CTRL,
                                                 CK_OUT3, CK_OUT3, CK_CTRL, CK_BIDIR},
  parameter int unsigned CTRL_IDX  [N_CELLS] = '{0, 1, 2, 3, 3, 3, 6, 6},
  parameter logic [N_CELLS-1:0] RST_VAL = 8'b0101_0100,
  parameter logic [N_CELLS-1:0] CTRLR   = 8'b0000_1000
) (
  input logic               tck_i,
  input logic               rst_ni,
  input logic               tlr_i,
  input logic               capture_i,
  input logic               shift_i,
  input logic               update_i,
  input logic               test_mode_i,
  input logic               tdi_i,
  input logic [N_CELLS-1:0] sys_out_i,
  input logic [N_CELLS-1:0] pin_out_o,
  input logic [N_CELLS-1:0] pin_oe_o,
  input logic [N_CELLS-1:0] cap_q,
  input logic [N_CELLS-1:0] upd_q
);
  logic [N_CELLS-1:0] upd_mask, drv_mask, forced_mask, two_mask;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_mask
    assign upd_mask[i]    = has_latch(CELL_KIND[i]);
    assign drv_mask[i]    = is_driver(CELL_KIND[i]);
    assign two_mask[i]    = CELL_KIND[i] == CK_OUT2;
    assign forced_mask[i] = is_gated(CELL_KIND[i]) && CTRLR[CTRL_IDX[i]];
  end

  AST_SHIFT_MOVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_i && !capture_i |=> cap_q == {$past(tdi_i), $past(cap_q[N_CELLS-1:1])}); // R2

  AST_UPD_HOLD: assert property (@(negedge tck_i) disable iff (!rst_ni)
    !update_i && !tlr_i |=> $stable(upd_q)); // R3

  AST_TLR_LOAD: assert property (@(negedge tck_i) disable iff (!rst_ni)
    tlr_i |=> ((upd_q ^ RST_VAL) & upd_mask) == '0); // R6

  AST_NORMAL_PASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !test_mode_i |-> ((pin_out_o ^ sys_out_i) & drv_mask) == '0); // R4

  AST_FORCED_OFF: assert property (@(posedge tck_i) disable iff (!rst_ni)
    test_mode_i && tlr_i |-> (pin_oe_o & forced_mask) == '0); // R7

  AST_TWO_STATE_ON: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (pin_oe_o & two_mask) == two_mask); // R11
endmodule

bind bsr_chain bsr_chain_chk #(
  .N_CELLS   (N_CELLS),
  .CELL_KIND (CELL_KIND),
  .CTRL_IDX  (CTRL_IDX),
  .RST_VAL   (RST_VAL),
  .CTRLR     (CTRLR)
) i_chk (.*);

// File: tb/test_bsr_chain.sv
module test_bsr_chain;
  logic       tck_i = 1'b0, rst_ni = 1'b0;
  logic       tlr_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0;
  logic       test_mode_i = 1'b0, tdi_i = 1'b0, tdo_o;
  logic [7:0] pin_in_i = '0, sys_out_i = '0, sys_oe_i = '0;
  logic [7:0] pin_out_o, pin_oe_o, core_in_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 tck_i = ~tck_i;

  bsr_chain i_bsr_chain (.*);

  typedef struct packed {
    logic       tm;
    logic [7:0] pin, so, se, din, cap, out, oe, core;
  } vec_t;

  // tm, pin_in, sys_out, sys_oe, shift-in | captured, pin_out, pin_oe, core_in
  localparam vec_t VECS [4] = '{
    '{1'b0, 8'hA5, 8'h3C, 8'h48, 8'hFF, 8'h7D, 8'h34, 8'hB4, 8'h81},
    '{1'b1, 8'h00, 8'h00, 8'h00, 8'h69, 8'h00, 8'h20, 8'hB4, 8'h01},
    '{1'b1, 8'hFF, 8'hFF, 8'h00, 8'h96, 8'hB7, 8'h94, 8'h04, 8'h82},
    '{1'b1, 8'h80, 8'h00, 8'hFF, 8'h00, 8'hC8, 8'h00, 8'h04, 8'h80}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge tck_i);
    #5;
  endtask

  task automatic shift_only(input logic [7:0] din, output logic [7:0] dout);
    shift_i = 1'b1;
    for (int k = 0; k < 8; k++) begin
      dout[k] = tdo_o;
      tdi_i   = din[k];
      cyc();
    end
    shift_i = 1'b0;
  endtask

  task automatic cap_shift(input logic [7:0] din, output logic [7:0] dout);
    capture_i = 1'b1;
    cyc();
    capture_i = 1'b0;
    shift_only(din, dout);
  endtask

  task automatic do_update();
    update_i = 1'b1;
    cyc();
    update_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    cyc();
    cyc();
    rst_ni = 1'b1;
    cyc();
    // R5 / R12: reset pattern seen through the pins in test mode
    chk("R5 tdo after reset", {7'd0, tdo_o}, 8'h00);
    test_mode_i = 1'b1;
    #1;
    chk("R5 pin_out reset values", pin_out_o, 8'h14);
    chk("R12 pin_oe reset values", pin_oe_o, 8'h84);
    chk("R10 core_in reset", core_in_o, 8'h00);
    cyc();

    // R1 R4 R8 R9 R10: vector table
    foreach (VECS[v]) begin
      test_mode_i = VECS[v].tm;
      pin_in_i    = VECS[v].pin;
      sys_out_i   = VECS[v].so;
      sys_oe_i    = VECS[v].se;
      cap_shift(VECS[v].din, got);
      chk($sformatf("R1/R9 capture v%0d", v), got, VECS[v].cap);
      do_update();
      chk($sformatf("R4 pin_out v%0d", v), pin_out_o, VECS[v].out);
      chk($sformatf("R8/R11 pin_oe v%0d", v), pin_oe_o, VECS[v].oe);
      chk($sformatf("R10 core_in v%0d", v), core_in_o, VECS[v].core);
    end

    // R6 R7: test-logic-reset
    test_mode_i = 1'b1;
    pin_in_i = '0; sys_out_i = '0; sys_oe_i = '0;
    cap_shift(8'hFF, got);
    do_update();
    chk("R4 all driven", pin_oe_o, 8'hB4);
    tlr_i = 1'b1;
    #1;
    chk("R7 forced group off", pin_oe_o, 8'h84);
    chk("R6 latches held before fall", pin_out_o, 8'hB4);
    @(posedge tck_i); #5;
    chk("R6 no change on rise", pin_out_o, 8'hB4);
    @(negedge tck_i); #5;
    chk("R6 reset values on fall", pin_out_o, 8'h14);
    chk("R6 enables after reset", pin_oe_o, 8'h84);
    tlr_i = 1'b0;
    #1;
    chk("R7 group stays off via latch", pin_oe_o, 8'h84);
    cyc();

    // R3: update only on falling edge, shifting does not reach pins
    cap_shift(8'h00, got);
    update_i = 1'b1;
    @(posedge tck_i); #5;
    chk("R3 pins hold at rise", pin_out_o, 8'h14);
    @(negedge tck_i); #5;
    update_i = 1'b0;
    chk("R3 pins change at fall", pin_out_o, 8'h00);
    chk("R3 enables change at fall", pin_oe_o, 8'h04);
    shift_only(8'hFF, got);
    cyc();
    chk("R3 shift leaves pins", pin_out_o, 8'h00);

    // R2: non-inverting pass through the chain
    shift_only(8'hC3, got);
    shift_only(8'h00, got);
    chk("R2 pattern out unchanged", got, 8'hC3);

    // R5: asynchronous reset mid-run
    shift_only(8'hFF, got);
    cap_shift(8'hFF, got);
    do_update();
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R5 async latch reset", pin_out_o, 8'h14);
    chk("R5 async stage clear", {7'd0, tdo_o}, 8'h00);
    cyc();
    rst_ni = 1'b1;
    cyc();
    finish_run();
  end
endmodule